// File: doc/BRIEF.md
# Per-Application Prefetch Behaviour Classifier

This block gives each application sharing an on-chip network a two-bit prefetch behaviour class, which the router arbiters use to order prefetch traffic. Each application has two counters. One counts the prefetches the application injects. The other counts the prefetches that later turn out to be useful. Both event strobes carry an application ID.

The block works in fixed time quanta. At the end of each quantum it grades every application on two points:
- whether its prefetches were accurate enough, and
- whether it issued many prefetches.

It then registers the resulting class and clears the counters. The class is held on the output for the whole of the next quantum, so the arbiters see a steady value. In static mode the counters are ignored, and each quantum boundary loads the class from a profile table supplied on an input instead.

Top module: `pf_app_classifier`

## Requirements
- R1: During reset and until the first quantum boundary, every application's class is 2'b10 and `quantum_end_o` is low. Application a occupies bits [2a+1:2a] of `cat_o`. Bit 1 is the accuracy-high flag and bit 0 is the volume-high flag.
- R2: `quantum_end_o` is high for one cycle in every `quantum_len_i` cycles. The first cycle after reset release is cycle 0 of the first quantum. A length of 0 or 1 makes it high in every cycle.
- R3: `cat_o` changes only in the cycle that follows a `quantum_end_o` pulse. It holds its value in every other cycle.
- R4: In dynamic mode, an application's accuracy flag is set when useful × 100 ≥ `acc_pct_i` × issued. Both counts cover the quantum that just ended.
- R5: In dynamic mode, an application's volume flag is set when its issued count for the quantum is at least `cnt_thresh_i`.
- R6: An application that issued no prefetches in a quantum is graded 2'b10. This holds even when it recorded useful events in that quantum.
- R7: Strobes that arrive in the cycle where `quantum_end_o` is high count toward the new quantum. Counters restart from zero at every boundary.
- R8: With `mode_static_i` high, each boundary loads `cat_o` from `profile_cat_i`, and the event strobes have no effect on the output. Between boundaries, `cat_o` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_static_i | input | 1 | 1: load classes from the profile table; 0: grade from the counters |
| quantum_len_i | input | QLEN_W | Quantum length in cycles |
| acc_pct_i | input | 8 | Accuracy threshold in percent |
| cnt_thresh_i | input | CNT_W | Issued-count threshold for the volume flag |
| profile_cat_i | input | 2*N_APP | Static class table, 2 bits per application |
| issue_vld_i | input | 1 | Prefetch-injected strobe |
| issue_app_i | input | APP_W | Application ID for the injected strobe |
| use_vld_i | input | 1 | Prefetch-useful strobe |
| use_app_i | input | APP_W | Application ID for the useful strobe |
| quantum_end_o | output | 1 | High in the last cycle of each quantum |
| cat_o | output | 2*N_APP | Registered classes, 2 bits per application |

## Verification
The assertions check four properties on every cycle:
- the output holds its value between boundaries;
- the boundary pulse lasts one cycle;
- the reset default stays until the first boundary;
- static mode loads the profile table.

The grading arithmetic, including the exact threshold equality and a zero issued count with nonzero useful events, can only be shown by the bench's scenarios. The same applies to attributing boundary-cycle strobes to the new quantum and to the quantum period. These scenarios compare counted traffic against classes computed independently.

// File: rtl/pf_cls_pkg.sv
package pf_cls_pkg;
  typedef logic [1:0] pf_cat_t;
  localparam int CAT_ACC_BIT = 1;
  localparam int CAT_CNT_BIT = 0;
  localparam pf_cat_t CAT_RESET = 2'b10;
  localparam int PCT_W = 8;
endpackage

// File: rtl/pf_quantum_timer.sv
module pf_quantum_timer #(
  parameter int QLEN_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [QLEN_W-1:0] len_i,
  output logic              end_o
);
  logic [QLEN_W-1:0] q_cnt;
  logic [QLEN_W:0]   q_next;

  assign q_next = {1'b0, q_cnt} + 1'b1;
  // len 0 and 1 both end every cycle
  assign end_o  = q_next >= {1'b0, len_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_cnt <= '0;
    else if (end_o) q_cnt <= '0;
    else            q_cnt <= q_next[QLEN_W-1:0];
  end
endmodule

// File: rtl/pf_event_counter.sv
module pf_event_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_o <= '0;
    else if (clr_i)                  cnt_o <= inc_i ? CNT_W'(1) : '0;
    else if (inc_i && !(&cnt_o))     cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/pf_app_grader.sv
module pf_app_grader
  import pf_cls_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic [CNT_W-1:0] issued_i,
  input  logic [CNT_W-1:0] useful_i,
  input  logic [PCT_W-1:0] acc_pct_i,
  input  logic [CNT_W-1:0] cnt_thr_i,
  output pf_cat_t          cat_o
);
  localparam int PROD_W = CNT_W + PCT_W;

  logic [PROD_W-1:0] useful_scaled;
  logic [PROD_W-1:0] issued_scaled;

  // cross-multiplied ratio test, no divider
  assign useful_scaled = PROD_W'(useful_i) * PROD_W'(100);
  assign issued_scaled = PROD_W'(issued_i) * PROD_W'(acc_pct_i);

  always_comb begin
    cat_o              = '0;
    cat_o[CAT_ACC_BIT] = useful_scaled >= issued_scaled;
    cat_o[CAT_CNT_BIT] = issued_i >= cnt_thr_i;
  end
endmodule

// File: rtl/pf_app_classifier.sv
module pf_app_classifier
  import pf_cls_pkg::*;
#(
  parameter int N_APP  = 4,
  parameter int CNT_W  = 16,
  parameter int QLEN_W = 16,
  localparam int APP_W = (N_APP > 1) ? $clog2(N_APP) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               mode_static_i,
  input  logic [QLEN_W-1:0]  quantum_len_i,
  input  logic [PCT_W-1:0]   acc_pct_i,
  input  logic [CNT_W-1:0]   cnt_thresh_i,
  input  logic [2*N_APP-1:0] profile_cat_i,
  input  logic               issue_vld_i,
  input  logic [APP_W-1:0]   issue_app_i,
  input  logic               use_vld_i,
  input  logic [APP_W-1:0]   use_app_i,
  output logic               quantum_end_o,
  output logic [2*N_APP-1:0] cat_o
);
  logic q_end;

  pf_quantum_timer #(.QLEN_W(QLEN_W)) timer_i (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .len_i (quantum_len_i),
    .end_o (q_end)
  );

  assign quantum_end_o = q_end;

  for (genvar a = 0; a < N_APP; a++) begin : g_app
    logic             iss_hit, use_hit;
    logic [CNT_W-1:0] iss_cnt, use_cnt;
    pf_cat_t          dyn_cat, cat_q;

    assign iss_hit = issue_vld_i && (issue_app_i == APP_W'(a));
    assign use_hit = use_vld_i   && (use_app_i   == APP_W'(a));

    pf_event_counter #(.CNT_W(CNT_W)) iss_ctr_i (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .inc_i (iss_hit),
      .clr_i (q_end),
      .cnt_o (iss_cnt)
    );

    pf_event_counter #(.CNT_W(CNT_W)) use_ctr_i (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .inc_i (use_hit),
      .clr_i (q_end),
      .cnt_o (use_cnt)
    );

    pf_app_grader #(.CNT_W(CNT_W)) grade_i (
      .issued_i (iss_cnt),
      .useful_i (use_cnt),
      .acc_pct_i(acc_pct_i),
      .cnt_thr_i(cnt_thresh_i),
      .cat_o    (dyn_cat)
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        cat_q <= CAT_RESET;
      else if (q_end)
        cat_q <= mode_static_i ? profile_cat_i[2*a +: 2] : dyn_cat;
    end

    assign cat_o[2*a +: 2] = cat_q;
  end
endmodule

// File: rtl/pf_app_classifier_chk.sv
module pf_app_classifier_chk #(
  parameter int N_APP  = 4,
  parameter int QLEN_W = 16
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               mode_static_i,
  input logic [QLEN_W-1:0]  quantum_len_i,
  input logic [2*N_APP-1:0] profile_cat_i,
  input logic               quantum_end_o,
  input logic [2*N_APP-1:0] cat_o
);
  logic seen_end;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            seen_end <= 1'b0;
    else if (quantum_end_o) seen_end <= 1'b1;
  end

  assert_reset_default_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !seen_end |-> (cat_o == {N_APP{2'b10}}));

  assert_single_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (quantum_end_o && quantum_len_i >= 2) |=> (!quantum_end_o || quantum_len_i < 2));

  assert_cat_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !quantum_end_o |=> $stable(cat_o));

  assert_static_load_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (quantum_end_o && mode_static_i) |=> (cat_o == $past(profile_cat_i)));
endmodule

bind pf_app_classifier pf_app_classifier_chk #(.N_APP(N_APP), .QLEN_W(QLEN_W)) chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .mode_static_i(mode_static_i),
  .quantum_len_i(quantum_len_i),
  .profile_cat_i(profile_cat_i),
  .quantum_end_o(quantum_end_o),
  .cat_o        (cat_o)
);

// File: tb/pf_app_classifier_tb_top.sv
module pf_app_classifier_tb_top;
  localparam int N_APP = 4;
  localparam int CNT_W = 16;
  localparam int QLEN_W = 16;
  localparam int APP_W = 2;
  localparam int NVEC = 3;
  // {expected cat_o, app3..app0 {issued[3:0], useful[3:0]}}
  localparam logic [39:0] VEC [NVEC] = '{
    {8'h63, 8'h82, 8'h00, 8'h41, 8'h88},
    {8'h8E, 8'h03, 8'h20, 8'h84, 8'h74},
    {8'hA4, 8'h63, 8'h55, 8'h80, 8'h10}
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic mode_static = 1'b0;
  logic [QLEN_W-1:0] qlen = 16'd40;
  logic [7:0] acc_pct = 8'd50;
  logic [CNT_W-1:0] cnt_thr = 16'd8;
  logic [2*N_APP-1:0] profile = '0;
  logic iss_vld = 1'b0, use_vld = 1'b0;
  logic [APP_W-1:0] iss_app = '0, use_app = '0;
  logic q_end;
  logic [2*N_APP-1:0] cat;

  int n_tests = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pf_app_classifier #(.N_APP(N_APP), .CNT_W(CNT_W), .QLEN_W(QLEN_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .mode_static_i(mode_static),
    .quantum_len_i(qlen), .acc_pct_i(acc_pct), .cnt_thresh_i(cnt_thr),
    .profile_cat_i(profile), .issue_vld_i(iss_vld), .issue_app_i(iss_app),
    .use_vld_i(use_vld), .use_app_i(use_app),
    .quantum_end_o(q_end), .cat_o(cat)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_boundary();
    while (!q_end) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic run_vec(input logic [39:0] v, input logic [7:0] prev);
    for (int c = 0; c < 32; c++) begin
      int a = c / 8;
      int k = c % 8;
      iss_vld = k < int'(v[8*a+4 +: 4]);
      use_vld = k < int'(v[8*a +: 4]);
      iss_app = APP_W'(a);
      use_app = APP_W'(a);
      if (c == 20) check(cat == prev, "R3 hold mid-quantum", cat, prev);
      @(negedge clk);
    end
    iss_vld = 1'b0;
    use_vld = 1'b0;
    wait_boundary();
    check(cat == v[39:32], "R4/R5 graded class", cat, v[39:32]);
  endtask

  initial begin
    #(20 * 100000);
    n_fail++;
    $display("FAIL watchdog: actual 0x0 expected 0x1");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] prev;
    int n;
    repeat (3) @(negedge clk);
    check(cat == 8'hAA, "R1 reset class", cat, 8'hAA);
    check(q_end == 1'b0, "R1 reset pulse", q_end, 0);
    rst_ni = 1'b1;

    prev = 8'hAA;
    for (int i = 0; i < NVEC; i++) begin
      run_vec(VEC[i], prev);
      prev = VEC[i][39:32];
    end

    // R2: period of a quiet quantum; R6 zero-issued grading
    n = 0;
    do begin @(negedge clk); n++; end while (!q_end);
    check(n == 39, "R2 quantum period", n, 39);
    @(negedge clk);
    check(cat == 8'hAA, "R6 zero issued class", cat, 8'hAA);

    // R7: strobes on the end cycle belong to the new quantum
    while (!q_end) @(negedge clk);
    for (int c = 0; c < 8; c++) begin
      iss_vld = 1'b1; use_vld = 1'b1; iss_app = '0; use_app = '0;
      @(negedge clk);
      if (c == 0) check(cat == 8'hAA, "R7 old quantum empty", cat, 8'hAA);
    end
    iss_vld = 1'b0; use_vld = 1'b0;
    wait_boundary();
    check(cat == 8'hAB, "R7 boundary events counted", cat, 8'hAB);

    // R8: static mode
    mode_static = 1'b1;
    profile = 8'h1B;
    #1;
    check(cat == 8'hAB, "R8 no load before boundary", cat, 8'hAB);
    for (int c = 0; c < 8; c++) begin
      iss_vld = 1'b1; iss_app = 2'd1;
      @(negedge clk);
    end
    iss_vld = 1'b0;
    wait_boundary();
    check(cat == 8'h1B, "R8 profile loaded", cat, 8'h1B);

    // R1: asynchronous reset mid-run
    rst_ni = 1'b0;
    #1;
    check(cat == 8'hAA, "R1 async reset class", cat, 8'hAA);
    check(q_end == 1'b0, "R1 async reset pulse", q_end, 0);
    @(negedge clk);
    mode_static = 1'b0;
    qlen = 16'd1;
    rst_ni = 1'b1;
    #1;
    check(q_end == 1'b1, "R2 length one pulse", q_end, 1);
    @(negedge clk);
    check(q_end == 1'b1, "R2 length one every cycle", q_end, 1);
    check(cat == 8'hAA, "R6 empty after short quantum", cat, 8'hAA);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule